// File: doc/BRIEF.md
# Input Change Detector with Interrupt

This block watches four general-purpose input pins. Each pin passes through a two-flop synchronizer and then a small qualification state machine. The machine accepts a new level only after the synchronized value has differed from the accepted level on two samples in a row. An accepted change sets a sticky per-pin change flag. If that pin's enable bit is on, the change also sets a summary bit, which is bit 7 of an 8-bit interrupt status word. The other seven status bits come straight from the `other_src` inputs. The status word is ANDed with an 8-bit mask, and the result drives a registered active-low interrupt pin.

A processor reaches four registers through `cpu_sel`, a read strobe and a write strobe. Select 0 is the change register. Reading it returns the sticky flags and the live synchronized levels, and the read clears both the flags and the summary bit. Select 1 is the status word, which is read-only and never masked. Select 2 is the mask. Select 3 is the per-pin enable. Each filter machine has two states. `FLT_STEADY` moves to `FLT_PROBE` when the synchronized level differs from the accepted level. From `FLT_PROBE`, the machine returns to `FLT_STEADY` either by committing, when the level still differs (the accepted level updates and a one-cycle event fires), or by discarding, when the level has returned.

Top module: `pin_change_irq`

## Requirements
- R1: A pin level held for good sets its change flag at the fourth rising clock edge after the level is applied. A pin pulse that lasts a single clock cycle sets no flag.
- R2: Reading select 0 returns the change flags in bits 7:4, with bit 4+i belonging to pin i. A flag sets on an accepted rising or falling change of its pin.
- R3: Bits 3:0 of select 0 return the current synchronized level of pins 3..0 (bit i is pin i), with no latching.
- R4: A read strobe with select 0 clears all change flags and status bit 7 at that clock edge.
- R5: Select 3, bits 3:0 (bit i for pin i), enables pin i's accepted changes to set status bit 7. A change on a disabled pin leaves bit 7 unchanged.
- R6: Reading select 1 returns {summary bit, other_src[6:0]}, whatever the mask value.
- R7: `irq_n` is driven low exactly when some bit of the status word and the same mask bit are both 1. It is registered, so it reflects the status and mask of the previous cycle.
- R8: An accepted change in the same cycle as a clearing read of select 0 leaves its flag set, and also leaves status bit 7 set if the pin is enabled.
- R9: After reset, the flags, the summary bit, the mask and the enables are 0 and `irq_n` is 1.
- R10: A write to select 2 loads all 8 mask bits. A write to select 3 loads bits 3:0 of the enable. Writes to select 0 or select 1 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 4 | Asynchronous general-purpose inputs |
| other_src | input | 7 | Status bits 6:0 from other sources |
| cpu_sel | input | 2 | Register select |
| cpu_rd | input | 1 | Read strobe (clears on select 0) |
| cpu_wr | input | 1 | Write strobe |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data for the current select |
| irq_n | output | 1 | Registered active-low interrupt |

## Verification
The clearing read and the commit of a qualified change can land on the same clock edge. In that case the new event must win over the clear. The bench toggles a pin and then issues a select-0 read at a sweep of offsets, so that one read falls exactly on the commit edge. A reference model runs cycle by cycle and is compared with `cpu_rdata` and `irq_n` on every cycle. It judges whether the flag, and the summary bit of an enabled pin, survived that read.

// File: rtl/pcd_pkg.sv
package pcd_pkg;
    localparam int PCD_PINS  = 4;
    localparam int PCD_DW    = 8;
    localparam int PCD_SRCS  = PCD_DW - 1;
    localparam int PCD_SYNC  = 2;

    typedef enum logic {
        FLT_STEADY = 1'b0,
        FLT_PROBE  = 1'b1
    } flt_state_e;

    typedef enum logic [1:0] {
        REG_CHG  = 2'd0,
        REG_STAT = 2'd1,
        REG_MASK = 2'd2,
        REG_ENAB = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/pcd_pin_filter.sv
module pcd_pin_filter
    import pcd_pkg::*;
#(
    parameter int SYNC_STAGES = PCD_SYNC
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_raw,
    output logic level_sync,
    output logic event_o
);
    logic [SYNC_STAGES-1:0] sync_q;
    flt_state_e             state_q, state_d;
    logic                   level_q, level_d;
    logic                   differ;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin_raw};
    end

    assign level_sync = sync_q[SYNC_STAGES-1];
    assign differ     = level_sync ^ level_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FLT_STEADY;
            level_q <= 1'b0;
        end else begin
            state_q <= state_d;
            level_q <= level_d;
        end
    end

    // next state and outputs
    always_comb begin
        state_d = state_q;
        level_d = level_q;
        event_o = 1'b0;
        unique case (state_q)
            FLT_STEADY: begin
                if (differ) state_d = FLT_PROBE;
            end
            FLT_PROBE: begin
                state_d = FLT_STEADY;
                if (differ) begin
                    level_d = level_sync;
                    event_o = 1'b1;
                end
            end
            default: state_d = FLT_STEADY;
        endcase
    end
endmodule

// File: rtl/pcd_event_latch.sv
module pcd_event_latch
    import pcd_pkg::*;
#(
    parameter int PINS = PCD_PINS
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PINS-1:0] evt,
    input  logic [PINS-1:0] enab,
    input  logic            clr,
    output logic [PINS-1:0] flags,
    output logic            summary
);
    // a fresh event is ORed after the clear so it is never lost
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags   <= '0;
            summary <= 1'b0;
        end else begin
            flags   <= (clr ? '0 : flags) | evt;
            summary <= (clr ? 1'b0 : summary) | (|(evt & enab));
        end
    end
endmodule

// File: rtl/pcd_irq_out.sv
module pcd_irq_out
    import pcd_pkg::*;
#(
    parameter int DW = PCD_DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] status,
    input  logic [DW-1:0] mask,
    output logic          irq_n
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_n <= 1'b1;
        else        irq_n <= ~|(status & mask);
    end
endmodule

// File: rtl/pin_change_irq.sv
module pin_change_irq
    import pcd_pkg::*;
#(
    parameter int PINS = PCD_PINS,
    parameter int DW   = PCD_DW,
    localparam int SRCS = DW - 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PINS-1:0] pin_in,
    input  logic [SRCS-1:0] other_src,
    input  logic [1:0]      cpu_sel,
    input  logic            cpu_rd,
    input  logic            cpu_wr,
    input  logic [DW-1:0]   cpu_wdata,
    output logic [DW-1:0]   cpu_rdata,
    output logic            irq_n
);
    logic [PINS-1:0] lvl, evt, flags, en_q;
    logic [DW-1:0]   mask_q, status;
    logic            summary, rd_clr;
    reg_sel_e        sel;

    assign sel    = reg_sel_e'(cpu_sel);
    assign rd_clr = cpu_rd && (sel == REG_CHG);

    for (genvar g = 0; g < PINS; g++) begin : g_pin
        pcd_pin_filter u_flt (
            .clk       (clk),
            .rst_n     (rst_n),
            .pin_raw   (pin_in[g]),
            .level_sync(lvl[g]),
            .event_o   (evt[g])
        );
    end

    pcd_event_latch #(.PINS(PINS)) u_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt    (evt),
        .enab   (en_q),
        .clr    (rd_clr),
        .flags  (flags),
        .summary(summary)
    );

    assign status = {summary, other_src};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
            en_q   <= '0;
        end else if (cpu_wr) begin
            if (sel == REG_MASK) mask_q <= cpu_wdata;
            if (sel == REG_ENAB) en_q   <= cpu_wdata[PINS-1:0];
        end
    end

    always_comb begin
        unique case (sel)
            REG_CHG:  cpu_rdata = {flags, lvl};
            REG_STAT: cpu_rdata = status;
            REG_MASK: cpu_rdata = mask_q;
            REG_ENAB: cpu_rdata = {{(DW-PINS){1'b0}}, en_q};
            default:  cpu_rdata = '0;
        endcase
    end

    pcd_irq_out #(.DW(DW)) u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .status(status),
        .mask  (mask_q),
        .irq_n (irq_n)
    );
endmodule

// File: rtl/pin_change_irq_chk.sv
module pin_change_irq_chk #(
    parameter int PINS = 4,
    parameter int DW   = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic [1:0]      cpu_sel,
    input logic            cpu_rd,
    input logic            irq_n,
    input logic [DW-1:0]   status,
    input logic [DW-1:0]   mask,
    input logic [PINS-1:0] flags,
    input logic [PINS-1:0] en,
    input logic [PINS-1:0] evt
);
    AST_IRQ_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (irq_n == ~|($past(status) & $past(mask)))); // R7

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && cpu_sel == 2'd0 && evt == '0) |=> (flags == '0 && !status[DW-1])); // R4

    AST_NO_LOST_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        (evt != '0) |=> ((flags & $past(evt)) == $past(evt))); // R8

    AST_SUMMARY_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[DW-1]) |-> ($past(evt & en) != '0)); // R5

    AST_FLAG_FROM_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((flags & ~$past(flags) & ~$past(evt)) == '0)); // R2
endmodule

bind pin_change_irq pin_change_irq_chk #(.PINS(PINS), .DW(DW)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .cpu_sel(cpu_sel),
    .cpu_rd (cpu_rd),
    .irq_n  (irq_n),
    .status (status),
    .mask   (mask_q),
    .flags  (flags),
    .en     (en_q),
    .evt    (evt)
);

// File: tb/pin_change_irq_bench.sv
`timescale 1ns/1ps
module pin_change_irq_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] pin_in = '0;
    logic [6:0] other_src = '0;
    logic [1:0] cpu_sel = '0;
    logic       cpu_rd = 1'b0;
    logic       cpu_wr = 1'b0;
    logic [7:0] cpu_wdata = '0;
    logic [7:0] cpu_rdata;
    logic       irq_n;

    int    n_chk = 0;
    int    n_fail = 0;
    string cur_req = "R9";
    bit    done = 1'b0;
    bit    started = 1'b0;

    always #2.5 clk = ~clk;

    pin_change_irq u_pin_change_irq (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .other_src(other_src),
        .cpu_sel(cpu_sel), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .irq_n(irq_n)
    );

    // behavioural reference model
    logic [3:0] m_s1 = '0, m_s2 = '0, m_acc = '0, m_pend = '0, m_flags = '0, m_en = '0;
    logic [3:0] m_dif, m_new;
    logic [7:0] m_mask = '0;
    logic       m_sum = 1'b0, m_irqn = 1'b1, m_clr;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 = '0; m_s2 = '0; m_acc = '0; m_pend = '0; m_flags = '0;
            m_en = '0; m_mask = '0; m_sum = 1'b0; m_irqn = 1'b1;
        end else begin
            m_dif   = m_s2 ^ m_acc;
            m_new   = m_pend & m_dif;
            m_clr   = cpu_rd && (cpu_sel == 2'd0);
            m_irqn  = ~|({m_sum, other_src} & m_mask);
            m_sum   = (m_clr ? 1'b0 : m_sum) | (|(m_new & m_en));
            m_flags = (m_clr ? 4'h0 : m_flags) | m_new;
            m_acc   = m_acc ^ m_new;
            m_pend  = ~m_pend & m_dif;
            if (cpu_wr && cpu_sel == 2'd2) m_mask = cpu_wdata;
            if (cpu_wr && cpu_sel == 2'd3) m_en = cpu_wdata[3:0];
            m_s2 = m_s1;
            m_s1 = pin_in;
        end
    end

    function automatic logic [7:0] exp_rdata();
        case (cpu_sel)
            2'd0:    return {m_flags, m_s2};
            2'd1:    return {m_sum, other_src};
            2'd2:    return m_mask;
            default: return {4'h0, m_en};
        endcase
    endfunction

    always @(negedge clk) begin
        if (started && !done) begin
            n_chk++;
            if (cpu_rdata !== exp_rdata() || irq_n !== m_irqn) begin
                n_fail++;
                $display("FAIL %s sel=%0d rdata act=%h exp=%h irq_n act=%b exp=%b",
                         cur_req, cpu_sel, cpu_rdata, exp_rdata(), irq_n, m_irqn);
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) begin @(negedge clk); #1; end
    endtask

    task automatic wr(input logic [1:0] s, input logic [7:0] d);
        cpu_sel = s; cpu_wdata = d; cpu_wr = 1'b1;
        tick(1);
        cpu_wr = 1'b0;
    endtask

    task automatic rd_clear();
        cpu_sel = 2'd0; cpu_rd = 1'b1;
        tick(1);
        cpu_rd = 1'b0;
    endtask

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog act=running exp=finished");
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        started = 1'b1;
        cur_req = "R9";
        tick(3);
        for (int s = 0; s < 4; s++) begin cpu_sel = 2'(s); tick(1); end
        rst_n = 1'b1;
        tick(2);

        cur_req = "R10";
        wr(2'd2, 8'hA5);
        wr(2'd0, 8'hFF);
        wr(2'd1, 8'hFF);
        wr(2'd3, 8'hF5);
        for (int s = 0; s < 4; s++) begin cpu_sel = 2'(s); tick(1); end

        cur_req = "R1";
        cpu_sel = 2'd0;
        pin_in[0] = 1'b1;
        tick(6);
        pin_in[1] = 1'b1; tick(1); pin_in[1] = 1'b0;
        tick(6);

        cur_req = "R3";
        pin_in = 4'b1010; tick(1);
        pin_in = 4'b0110; tick(6);

        cur_req = "R4";
        rd_clear();
        tick(2);

        cur_req = "R5";
        wr(2'd3, 8'h04);
        wr(2'd2, 8'h00);
        cpu_sel = 2'd1;
        pin_in[1] = 1'b0; tick(6);
        pin_in[2] = 1'b0; tick(6);
        cpu_sel = 2'd0; tick(1);

        cur_req = "R6";
        other_src = 7'h55;
        cpu_sel = 2'd1; tick(3);

        cur_req = "R7";
        wr(2'd2, 8'h80); cpu_sel = 2'd1; tick(3);
        wr(2'd2, 8'h00); cpu_sel = 2'd1; tick(3);
        wr(2'd2, 8'h01); cpu_sel = 2'd1; tick(3);
        other_src = 7'h00; tick(3);
        rd_clear(); tick(3);

        cur_req = "R8";
        wr(2'd3, 8'h0F);
        wr(2'd2, 8'h80);
        for (int off = 1; off < 7; off++) begin
            cpu_sel = 2'd0;
            pin_in[3] = ~pin_in[3];
            tick(off);
            rd_clear();
            tick(8);
            rd_clear();
            tick(3);
        end

        cur_req = "R2";
        pin_in = 4'hF; tick(7);
        pin_in = 4'h0; tick(7);
        rd_clear(); tick(3);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule